// File: doc/BRIEF.md
# Split-Byte Register Bus Datapath

This block is the register-transfer core of a small processor. One 16-line bus joins every storage element. Four general registers are each split into a low byte and a high byte. Each byte is wired to one fixed lane of the bus: low bytes use lines 7:0 and high bytes use lines 15:8. Two 16-bit index registers behave as single units. Two temporary registers hold the operands of an ALU. A stub ALU that adds its operands can drive its result back onto the bus. An external operand input lets a value enter the datapath.

Each cycle the block may receive one move command. The command names a source code, a destination code, a size (word or byte) and, for byte moves, the lane of each side. The command is captured on a clock edge. During the next cycle the matching output enables and load strobes are asserted as registered outputs, and the source drives the bus. The destination loads on the edge that ends that cycle. A move that the wiring cannot perform is flagged with an error pulse for one cycle. Such a move drives nothing and loads nothing.

Top module: `lane_bus_dp`

## Requirements
- R1: After a synchronous active-high reset, every register holds 0. `oe_o`, `ld_o` and `err_o` are 0, and `bus_o`, `x_o` and `y_o` read 0.
- R2: A word move captured at edge k asserts the enables and strobes of its source and destination during the cycle after edge k. Source codes are: 0–3 for the general registers A..D, 4 for index I0, 5 for index I1, 6 for the ALU result, 7 for the external input. Destination codes are: 0–3 for A..D, 4 for I0, 5 for I1, 6 for operand X, 7 for operand Y. A word move between general registers sets both half bits, `oe_o[2g]` and `oe_o[2g+1]`, of the source g and both `ld_o` half bits of the destination.
- R3: A byte move with `mv_wide`=0 is legal only when both codes are 0–3 and `mv_src_hi` equals `mv_dst_hi`. Bit index 2g+hi is the byte of register g in lane hi. Only that source bit of `oe_o` and that destination bit of `ld_o` are set, and the other bus lane reads 0.
- R4: A byte move whose source lane differs from its destination lane is rejected. `err_o` is 1 for one cycle, `oe_o` and `ld_o` are 0, and no register changes.
- R5: A byte move whose source or destination code is 4–7 is rejected in the same way as R4.
- R6: The index registers take part only in word moves. Source or destination I0 uses bit 8 and I1 uses bit 9 of `oe_o` and of `ld_o`.
- R7: Operand X (load bit 10) and operand Y (load bit 11) load the whole bus, and they are always visible on `x_o` and `y_o`.
- R8: The ALU result, X+Y modulo 2^16, reaches the bus only while `oe_o[10]` is set. A lane that no enabled source drives reads 0.
- R9: The external source (`oe_o[11]`) drives the value that `ext_din` had at the edge that captured the command.
- R10: A load takes effect on the edge that ends the cycle in which the source drives the bus. A move issued on the next cycle already sees the new value.
- R11: In every cycle at most one source drives each lane. On each lane the enables are zero-or-one-hot.
- R12: While `mv_valid` is 0, the other command inputs are ignored: no enable, strobe or error follows, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_valid | input | 1 | Move command present this cycle |
| mv_wide | input | 1 | 1 = word move, 0 = byte move |
| mv_src | input | 3 | Source code |
| mv_src_hi | input | 1 | Byte moves: source lane (1 = high) |
| mv_dst | input | 3 | Destination code |
| mv_dst_hi | input | 1 | Byte moves: destination lane (1 = high) |
| ext_din | input | 16 | External operand, sampled with the command |
| oe_o | output | 12 | Registered output enables |
| ld_o | output | 12 | Registered load strobes |
| err_o | output | 1 | Rejected-move pulse |
| bus_o | output | 16 | Shared bus value |
| x_o | output | 16 | Operand X register |
| y_o | output | 16 | Operand Y register |

## Verification
The hardest case to create is back-to-back dependence. A register loaded at one edge must be read by the move captured at that same edge. The result depends on which moves issued in the same cycle. The stimulus issues moves on consecutive cycles and chains each read to the previous load. It also injects illegal byte moves into those chains, so that any stray strobe changes a value that a later legal word move exposes on the bus. A long deterministic pseudo-random run then mixes all codes, sizes and lanes against the reference model.

// File: rtl/lane_bus_pkg.sv
package lane_bus_pkg;
  localparam int NUM_GP = 4;
  localparam int CODE_W = 3;
  localparam int HALF_N = 2 * NUM_GP;
  localparam int EN_W   = HALF_N + 4;

  // whole-word enable / strobe slots after the byte halves
  localparam int OE_I0  = HALF_N;
  localparam int OE_I1  = HALF_N + 1;
  localparam int OE_ALU = HALF_N + 2;
  localparam int OE_EXT = HALF_N + 3;
  localparam int LD_I0  = HALF_N;
  localparam int LD_I1  = HALF_N + 1;
  localparam int LD_X   = HALF_N + 2;
  localparam int LD_Y   = HALF_N + 3;

  localparam logic [CODE_W-1:0] C_I0 = 3'd4;
  localparam logic [CODE_W-1:0] C_I1 = 3'd5;
  localparam logic [CODE_W-1:0] C_6  = 3'd6; // source: ALU, dest: X
  localparam logic [CODE_W-1:0] C_7  = 3'd7; // source: external, dest: Y

  typedef struct packed {
    logic              valid;
    logic              wide;
    logic [CODE_W-1:0] src;
    logic              src_hi;
    logic [CODE_W-1:0] dst;
    logic              dst_hi;
  } move_t;
endpackage

// File: rtl/lane_bus_dec.sv
module lane_bus_dec
  import lane_bus_pkg::*;
(
  input  move_t           cmd,
  output logic [EN_W-1:0] oe,
  output logic [EN_W-1:0] ld,
  output logic            err
);
  logic src_gp, dst_gp;

  assign src_gp = cmd.src < CODE_W'(NUM_GP);
  assign dst_gp = cmd.dst < CODE_W'(NUM_GP);

  always_comb begin
    oe  = '0;
    ld  = '0;
    err = 1'b0;
    if (cmd.valid) begin
      if (!cmd.wide) begin
        if (src_gp && dst_gp && (cmd.src_hi == cmd.dst_hi)) begin
          for (int g = 0; g < NUM_GP; g++) begin
            if (cmd.src == CODE_W'(g)) oe[2*g + (cmd.src_hi ? 1 : 0)] = 1'b1;
            if (cmd.dst == CODE_W'(g)) ld[2*g + (cmd.dst_hi ? 1 : 0)] = 1'b1;
          end
        end else begin
          err = 1'b1;
        end
      end else begin
        for (int g = 0; g < NUM_GP; g++) begin
          if (cmd.src == CODE_W'(g)) begin
            oe[2*g]   = 1'b1;
            oe[2*g+1] = 1'b1;
          end
          if (cmd.dst == CODE_W'(g)) begin
            ld[2*g]   = 1'b1;
            ld[2*g+1] = 1'b1;
          end
        end
        case (cmd.src)
          C_I0:    oe[OE_I0]  = 1'b1;
          C_I1:    oe[OE_I1]  = 1'b1;
          C_6:     oe[OE_ALU] = 1'b1;
          C_7:     oe[OE_EXT] = 1'b1;
          default: ;
        endcase
        case (cmd.dst)
          C_I0:    ld[LD_I0] = 1'b1;
          C_I1:    ld[LD_I1] = 1'b1;
          C_6:     ld[LD_X]  = 1'b1;
          C_7:     ld[LD_Y]  = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lane_bus_regs.sv
module lane_bus_regs
  import lane_bus_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [EN_W-1:0]               ld,
  input  logic [BUS_W-1:0]              bus,
  output logic [HALF_N-1:0][LANE_W-1:0] half_q,
  output logic [3:0][BUS_W-1:0]         word_q   // I0, I1, X, Y
);
  genvar h, k;
  generate
    for (h = 0; h < HALF_N; h++) begin : g_half
      localparam int LANE = h % 2;
      always_ff @(posedge clk) begin
        if (rst)        half_q[h] <= '0;
        else if (ld[h]) half_q[h] <= bus[LANE*LANE_W +: LANE_W];
      end
    end
    for (k = 0; k < 4; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)               word_q[k] <= '0;
        else if (ld[HALF_N+k]) word_q[k] <= bus;
      end
    end
  endgenerate

  // R7
  x_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld[LD_X] |=> word_q[2] == $past(bus));
endmodule

// File: rtl/lane_bus_mux.sv
module lane_bus_mux
  import lane_bus_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [EN_W-1:0]               oe,
  input  logic [HALF_N-1:0][LANE_W-1:0] half_q,
  input  logic [3:0][BUS_W-1:0]         word_q,
  input  logic [BUS_W-1:0]              alu_z,
  input  logic [BUS_W-1:0]              ext_q,
  output logic [BUS_W-1:0]              bus
);
  logic [LANE_W-1:0] lo, hi;
  logic [BUS_W-1:0]  full;
  logic [NUM_GP+3:0] lo_drv, hi_drv;

  always_comb begin
    lo = '0;
    hi = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      if (oe[2*g])   lo = lo | half_q[2*g];
      if (oe[2*g+1]) hi = hi | half_q[2*g+1];
      lo_drv[g] = oe[2*g];
      hi_drv[g] = oe[2*g+1];
    end
    full = '0;
    if (oe[OE_I0])  full = full | word_q[0];
    if (oe[OE_I1])  full = full | word_q[1];
    if (oe[OE_ALU]) full = full | alu_z;
    if (oe[OE_EXT]) full = full | ext_q;
    lo_drv[NUM_GP+3:NUM_GP] = oe[OE_EXT:OE_I0];
    hi_drv[NUM_GP+3:NUM_GP] = oe[OE_EXT:OE_I0];
  end

  assign bus = {hi, lo} | full;

  // R11
  lane_lo_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lo_drv));
  // R11
  lane_hi_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hi_drv));
endmodule

// File: rtl/lane_bus_dp.sv
module lane_bus_dp
  import lane_bus_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int BUS_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mv_valid,
  input  logic              mv_wide,
  input  logic [2:0]        mv_src,
  input  logic              mv_src_hi,
  input  logic [2:0]        mv_dst,
  input  logic              mv_dst_hi,
  input  logic [BUS_W-1:0]  ext_din,
  output logic [EN_W-1:0]   oe_o,
  output logic [EN_W-1:0]   ld_o,
  output logic              err_o,
  output logic [BUS_W-1:0]  bus_o,
  output logic [BUS_W-1:0]  x_o,
  output logic [BUS_W-1:0]  y_o
);
  move_t                         cmd;
  logic [EN_W-1:0]               dec_oe, dec_ld, oe_q, ld_q;
  logic                          dec_err, err_q;
  logic [BUS_W-1:0]              ext_q, bus, alu_z;
  logic [HALF_N-1:0][LANE_W-1:0] half_q;
  logic [3:0][BUS_W-1:0]         word_q;

  assign cmd = '{valid: mv_valid, wide: mv_wide, src: mv_src, src_hi: mv_src_hi,
                 dst: mv_dst, dst_hi: mv_dst_hi};

  lane_bus_dec u_dec (.cmd(cmd), .oe(dec_oe), .ld(dec_ld), .err(dec_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      ld_q  <= '0;
      err_q <= 1'b0;
      ext_q <= '0;
    end else begin
      oe_q  <= dec_oe;
      ld_q  <= dec_ld;
      err_q <= dec_err;
      ext_q <= ext_din;
    end
  end

  lane_bus_regs #(.LANE_W(LANE_W)) u_regs (
    .clk(clk), .rst(rst), .ld(ld_q), .bus(bus), .half_q(half_q), .word_q(word_q));

  assign alu_z = word_q[2] + word_q[3];

  lane_bus_mux #(.LANE_W(LANE_W)) u_mux (
    .clk(clk), .rst(rst), .oe(oe_q), .half_q(half_q), .word_q(word_q),
    .alu_z(alu_z), .ext_q(ext_q), .bus(bus));

  assign oe_o  = oe_q;
  assign ld_o  = ld_q;
  assign err_o = err_q;
  assign bus_o = bus;
  assign x_o   = word_q[2];
  assign y_o   = word_q[3];

  // R4
  reject_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> ($stable(half_q) && $stable(word_q)));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mv_valid |=> (oe_q == '0 && ld_q == '0 && !err_q));
  // R6
  index_full_word_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_q[LD_I0] || ld_q[LD_I1]) |-> ($countones(oe_q & ~EN_W'(32'h0AA)) >= 1
                                       && $countones(oe_q & ~EN_W'(32'h055)) >= 1));
  // R3
  byte_lane_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(ld_q) == 1 && ld_q[HALF_N-1:0] != '0) |->
      ($countones(oe_q) == 1 && ((ld_q & EN_W'(32'h0AA)) != '0) == ((oe_q & EN_W'(32'h0AA)) != '0)));
endmodule

// File: tb/lane_bus_dp_bench.sv
module lane_bus_dp_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        mv_valid, mv_wide, mv_src_hi, mv_dst_hi;
  logic [2:0]  mv_src, mv_dst;
  logic [15:0] ext_din;
  logic [11:0] oe_o, ld_o;
  logic        err_o;
  logic [15:0] bus_o, x_o, y_o;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [7:0]  m_half [8];
  logic [15:0] m_i0, m_i1, m_x, m_y;
  logic [15:0] held_ext;

  always #5 clk = ~clk;

  lane_bus_dp u_lane_bus_dp (
    .clk(clk), .rst(rst), .mv_valid(mv_valid), .mv_wide(mv_wide),
    .mv_src(mv_src), .mv_src_hi(mv_src_hi), .mv_dst(mv_dst), .mv_dst_hi(mv_dst_hi),
    .ext_din(ext_din), .oe_o(oe_o), .ld_o(ld_o), .err_o(err_o),
    .bus_o(bus_o), .x_o(x_o), .y_o(y_o));

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic w,
                      input logic [2:0] s, input logic sh, input logic [2:0] d,
                      input logic dh, input logic [15:0] din);
    logic [11:0] eo, el;
    logic        ee;
    logic [15:0] eb;
    logic [7:0]  bv;
    int          si, di;
    mv_valid = v; mv_wide = w; mv_src = s; mv_src_hi = sh;
    mv_dst = d; mv_dst_hi = dh; ext_din = din;
    @(posedge clk);
    held_ext = din;
    #1;
    chk("R7", "x_o", {16'h0, x_o}, {16'h0, m_x});
    chk("R7", "y_o", {16'h0, y_o}, {16'h0, m_y});
    eo = '0; el = '0; ee = 1'b0; eb = '0;
    si = int'(s); di = int'(d);
    if (v) begin
      if (!w) begin
        if (si < 4 && di < 4 && sh == dh) begin
          eo[2*si + (sh ? 1 : 0)] = 1'b1;
          el[2*di + (dh ? 1 : 0)] = 1'b1;
          bv = m_half[2*si + (sh ? 1 : 0)];
          eb = sh ? {bv, 8'h00} : {8'h00, bv};
        end else begin
          ee = 1'b1;
        end
      end else begin
        if (si < 4) begin
          eo[2*si] = 1'b1; eo[2*si+1] = 1'b1;
          eb = {m_half[2*si+1], m_half[2*si]};
        end else if (si == 4) begin eo[8]  = 1'b1; eb = m_i0; end
        else if (si == 5)     begin eo[9]  = 1'b1; eb = m_i1; end
        else if (si == 6)     begin eo[10] = 1'b1; eb = m_x + m_y; end
        else                  begin eo[11] = 1'b1; eb = held_ext; end
        if (di < 4) begin el[2*di] = 1'b1; el[2*di+1] = 1'b1; end
        else el[di + 4] = 1'b1;
      end
    end
    chk(tag, "oe_o", {20'h0, oe_o}, {20'h0, eo});
    chk(tag, "ld_o", {20'h0, ld_o}, {20'h0, el});
    chk(tag, "err_o", {31'h0, err_o}, {31'h0, ee});
    chk(tag, "bus_o", {16'h0, bus_o}, {16'h0, eb});
    // R11 per-lane single driver
    chk("R11", "lo lane drivers",
        32'($countones({oe_o[11:8], oe_o[6], oe_o[4], oe_o[2], oe_o[0]}) <= 1), 32'd1);
    chk("R11", "hi lane drivers",
        32'($countones({oe_o[11:8], oe_o[7], oe_o[5], oe_o[3], oe_o[1]}) <= 1), 32'd1);
    for (int h = 0; h < 8; h++)
      if (el[h]) m_half[h] = (h % 2 == 1) ? eb[15:8] : eb[7:0];
    if (el[8])  m_i0 = eb;
    if (el[9])  m_i1 = eb;
    if (el[10]) m_x  = eb;
    if (el[11]) m_y  = eb;
    mv_valid = 1'b0;
  endtask

  // word read of every register to expose state at the bus
  task automatic dump(input string tag);
    for (int r = 0; r < 6; r++) step(tag, 1'b1, 1'b1, 3'(r), 1'b0, 3'd6, 1'b0, 16'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int h = 0; h < 8; h++) m_half[h] = '0;
    m_i0 = '0; m_i1 = '0; m_x = '0; m_y = '0; held_ext = '0;
    rst = 1'b1; mv_valid = 1'b0; mv_wide = 1'b0; mv_src = '0; mv_dst = '0;
    mv_src_hi = 1'b0; mv_dst_hi = 1'b0; ext_din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "oe_o", {20'h0, oe_o}, 32'h0);
    chk("R1", "ld_o", {20'h0, ld_o}, 32'h0);
    chk("R1", "err_o", {31'h0, err_o}, 32'h0);
    chk("R1", "bus_o", {16'h0, bus_o}, 32'h0);
    rst = 1'b0;
    step("R1", 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 16'h0);
    dump("R1");
    // R9 external loads into each register
    step("R9", 1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 16'h1234);
    step("R9", 1'b1, 1'b1, 3'd7, 1'b0, 3'd1, 1'b0, 16'hABCD);
    step("R9", 1'b1, 1'b1, 3'd7, 1'b0, 3'd2, 1'b0, 16'h5A5A);
    step("R9", 1'b1, 1'b1, 3'd7, 1'b0, 3'd3, 1'b0, 16'hC33C);
    step("R6", 1'b1, 1'b1, 3'd7, 1'b0, 3'd4, 1'b0, 16'h0F0F);
    step("R6", 1'b1, 1'b1, 3'd7, 1'b0, 3'd5, 1'b0, 16'hF00D);
    // R2 word moves between general registers
    step("R2", 1'b1, 1'b1, 3'd0, 1'b0, 3'd2, 1'b0, 16'h0);
    step("R2", 1'b1, 1'b1, 3'd2, 1'b0, 3'd3, 1'b0, 16'h0);
    // R3 byte moves in lane
    step("R3", 1'b1, 1'b0, 3'd1, 1'b0, 3'd0, 1'b0, 16'h0);
    step("R3", 1'b1, 1'b0, 3'd1, 1'b1, 3'd3, 1'b1, 16'h0);
    // R4 lane-crossing rejects
    step("R4", 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 16'h0);
    step("R4", 1'b1, 1'b0, 3'd2, 1'b1, 3'd1, 1'b0, 16'h0);
    // R5 byte moves touching index, ALU, X, Y or external
    step("R5", 1'b1, 1'b0, 3'd1, 1'b0, 3'd4, 1'b0, 16'h0);
    step("R5", 1'b1, 1'b0, 3'd5, 1'b1, 3'd2, 1'b1, 16'h0);
    step("R5", 1'b1, 1'b0, 3'd6, 1'b0, 3'd0, 1'b0, 16'h0);
    step("R5", 1'b1, 1'b0, 3'd7, 1'b0, 3'd0, 1'b0, 16'hFFFF);
    step("R5", 1'b1, 1'b0, 3'd0, 1'b0, 3'd7, 1'b0, 16'h0);
    dump("R4");
    // R6 index word moves
    step("R6", 1'b1, 1'b1, 3'd4, 1'b0, 3'd1, 1'b0, 16'h0);
    step("R6", 1'b1, 1'b1, 3'd5, 1'b0, 3'd4, 1'b0, 16'h0);
    step("R6", 1'b1, 1'b1, 3'd3, 1'b0, 3'd5, 1'b0, 16'h0);
    // R7 / R8 operands and ALU
    step("R7", 1'b1, 1'b1, 3'd0, 1'b0, 3'd6, 1'b0, 16'h0);
    step("R7", 1'b1, 1'b1, 3'd1, 1'b0, 3'd7, 1'b0, 16'h0);
    step("R8", 1'b1, 1'b1, 3'd6, 1'b0, 3'd2, 1'b0, 16'h0);
    step("R8", 1'b1, 1'b1, 3'd7, 1'b0, 3'd6, 1'b0, 16'hFFFF);
    step("R8", 1'b1, 1'b1, 3'd6, 1'b0, 3'd7, 1'b0, 16'h0);
    step("R8", 1'b1, 1'b1, 3'd6, 1'b0, 3'd0, 1'b0, 16'h0);
    // R10 back-to-back dependence
    step("R10", 1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 16'h6789);
    step("R10", 1'b1, 1'b1, 3'd0, 1'b0, 3'd1, 1'b0, 16'h0);
    step("R10", 1'b1, 1'b0, 3'd1, 1'b1, 3'd2, 1'b1, 16'h0);
    step("R10", 1'b1, 1'b1, 3'd2, 1'b0, 3'd4, 1'b0, 16'h0);
    // R12 idle with junk fields
    step("R12", 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 16'hDEAD);
    step("R12", 1'b0, 1'b1, 3'd7, 1'b0, 3'd3, 1'b0, 16'hBEEF);
    dump("R12");
    // mixed deterministic run
    lf = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R2", lf[0] | lf[1], lf[2], lf[5:3], lf[6], lf[9:7], lf[6] ^ (lf[10] & lf[11]),
           lf[31:16]);
    end
    dump("R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule